// File: doc/BRIEF.md
# Trace Capture Trigger Controller

This block steers an eight-word capture buffer for an on-chip debug unit. Each cycle the CPU side may offer a capture word with a valid strobe. Software sets an enable bit and an arm bit through a control write, and a comparator match then decides where the recorded window sits. In begin mode the match opens the window and the buffer fills until it holds eight words. In end mode the buffer records all the time it is armed, dropping its oldest word when it overflows, and the match freezes it.

A select bit picks the qualifying signal. It is either the raw comparator pulse, or the same pulse after a fixed opcode-tracking latency, which is modelled here as a short delay line. The run ends when the buffer fills (begin mode) or when the trigger arrives (end mode). At that point the armed flag drops and, if breaks are enabled, a one-cycle break request goes to the CPU.

Once the unit is disarmed, software drains the buffer oldest-first through a show-ahead read port.

Top module: `dbg_trace_trig`

## Requirements
- R1: After synchronous reset, `armed` is 0, `entry_cnt` is 0 and `brk_req` is 0.
- R2: A control write with `cfg_enable`=1 and `cfg_arm`=1 sets `armed` from the next cycle on. It also empties the buffer (`entry_cnt`=0), so the new run never holds words from an earlier one.
- R3: A control write with `cfg_enable`=0 or `cfg_arm`=0 clears `armed` from the next cycle on. It raises no break request and keeps the stored words.
- R4: With `trig_sel`=0 the qualified trigger is `cmp_match` in the same cycle. With `trig_sel`=1 it is `cmp_match` from two cycles earlier (tracking latency `TRACK_LAT`=2). The delay line also runs while the unit is disarmed.
- R5: In begin mode (`cfg_begin`=1), no word is stored until the qualified trigger. The trigger-cycle word is not stored. From the next cycle on, every valid word is stored.
- R6: In begin mode, the eighth stored word ends the run: `armed` reads 0 from the next cycle.
- R7: In end mode (`cfg_begin`=0), every valid word is stored while armed. `entry_cnt` saturates at 8, and a ninth word replaces the oldest one.
- R8: In end mode, a qualified trigger ends the run. A valid word in the trigger cycle is still stored, and `armed` reads 0 from the next cycle.
- R9: When a run ends by itself and breaks were enabled (`cfg_brk_en` of the last write = 1), `brk_req` is high for exactly the first disarmed cycle. It is never high otherwise.
- R10: While disarmed with `entry_cnt`>0, `rd_data` shows the oldest stored word. `rd_req` removes it and decrements `entry_cnt`.
- R11: `rd_req` while armed has no effect on `entry_cnt` or on the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_data | input | WORD_W | Word offered for capture |
| cap_valid | input | 1 | Capture word is valid this cycle |
| cmp_match | input | 1 | Comparator match pulse |
| trig_sel | input | 1 | 0: raw match, 1: tracked (delayed) match |
| cfg_we | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Module enable value to write |
| cfg_arm | input | 1 | Arm value to write |
| cfg_begin | input | 1 | 1: begin mode, 0: end mode |
| cfg_brk_en | input | 1 | Break-request enable value to write |
| rd_req | input | 1 | Pop the oldest stored word |
| rd_data | output | WORD_W | Oldest stored word (valid when entry_cnt>0) |
| entry_cnt | output | $clog2(DEPTH+1) | Number of stored words, 0 to 8 |
| armed | output | 1 | Armed status flag |
| brk_req | output | 1 | One-cycle break request to the CPU |

## Verification
The sharpest collision is in end mode. A tracked trigger lands in the same cycle as a valid word while the buffer already holds eight words, so that word must overwrite the oldest entry and freeze the buffer in one step. The bench provokes this by pulsing the match with `trig_sel`=1 two cycles before a word it keeps streaming. A behavioural queue model predicts the result, and the surviving contents are then drained and compared word by word. A second overlap is a read request arriving while armed in the same cycle as capture traffic; the model must show the read had no effect.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_WAIT = 2'd1,
        RUN_FILL = 2'd2,
        RUN_ROLL = 2'd3
    } run_state_t;

    typedef struct packed {
        logic enable;
        logic arm;
        logic begin_mode;
        logic brk_en;
    } cfg_t;

    function automatic logic cfg_starts_run(input cfg_t c);
        return c.enable & c.arm;
    endfunction

endpackage

// File: rtl/dbg_trig_qual.sv
module dbg_trig_qual #(
    parameter int TRACK_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic sel,
    output logic qual
);
    logic tracked;

    generate
        if (TRACK_LAT == 1) begin : g_one
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= match;
            end
            assign tracked = stage_q;
        end else begin : g_many
            logic [TRACK_LAT-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[TRACK_LAT-2:0], match};
            end
            assign tracked = pipe_q[TRACK_LAT-1];
        end
    endgenerate

    assign qual = sel ? tracked : match;

endmodule

// File: rtl/dbg_trace_store.sv
module dbg_trace_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic                         pop,
    output logic [WORD_W-1:0]            rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  rd_idx;

    assign rd_idx  = wptr_q - PTR_W'(cnt_q);
    assign rd_data = mem_q[rd_idx];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (wr_en && !clear) mem_q[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            wptr_q <= wptr_q + PTR_W'(1);
            if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    p_pop_dec_r10: assert property (@(posedge clk) disable iff (rst)
        (pop && !wr_en && !clear && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
    import dbg_trace_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  cfg_t                        cfg,
    input  logic                        qual,
    input  logic                        cap_valid,
    input  logic                        rd_req,
    input  logic [$clog2(DEPTH+1)-1:0]  cnt,
    output logic                        armed,
    output logic                        brk_req,
    output logic                        store_wr,
    output logic                        store_clear,
    output logic                        store_pop
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    run_state_t state_q, state_d;
    logic       brk_en_q;
    logic       brk_q;
    logic       stop;

    always_comb begin
        state_d     = state_q;
        store_wr    = 1'b0;
        store_clear = 1'b0;
        stop        = 1'b0;
        unique case (state_q)
            RUN_WAIT: if (qual) state_d = RUN_FILL;
            RUN_FILL: begin
                if (cap_valid) begin
                    store_wr = 1'b1;
                    if (cnt == LAST) stop = 1'b1;
                end
            end
            RUN_ROLL: begin
                store_wr = cap_valid;
                if (qual) stop = 1'b1;
            end
            default: ;
        endcase
        if (stop) state_d = RUN_IDLE;
        if (cfg_we) begin
            store_wr = 1'b0;
            stop     = 1'b0;
            if (cfg_starts_run(cfg)) begin
                store_clear = 1'b1;
                state_d     = cfg.begin_mode ? RUN_WAIT : RUN_ROLL;
            end else begin
                state_d = RUN_IDLE;
            end
        end
    end

    assign store_pop = rd_req && (state_q == RUN_IDLE) && (cnt != '0) && !store_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RUN_IDLE;
            brk_en_q <= 1'b0;
            brk_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            brk_q   <= stop && brk_en_q;
            if (cfg_we) brk_en_q <= cfg.brk_en;
        end
    end

    assign armed   = (state_q != RUN_IDLE);
    assign brk_req = brk_q;

    p_brk_disarmed_r9: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> !armed);

    p_brk_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> !brk_req);

    p_fill_below_full_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RUN_FILL) |-> cnt < FULL);

    p_wait_no_store_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RUN_WAIT && !cfg_we) |=> cnt == $past(cnt));

endmodule

// File: rtl/dbg_trace_trig.sv
module dbg_trace_trig
    import dbg_trace_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int DEPTH     = 8,
    parameter int TRACK_LAT = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WORD_W-1:0]           cap_data,
    input  logic                        cap_valid,
    input  logic                        cmp_match,
    input  logic                        trig_sel,
    input  logic                        cfg_we,
    input  logic                        cfg_enable,
    input  logic                        cfg_arm,
    input  logic                        cfg_begin,
    input  logic                        cfg_brk_en,
    input  logic                        rd_req,
    output logic [WORD_W-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  entry_cnt,
    output logic                        armed,
    output logic                        brk_req
);
    localparam int CNT_W = $clog2(DEPTH+1);

    cfg_t             cfg_in;
    logic             qual;
    logic             store_wr;
    logic             store_clear;
    logic             store_pop;
    logic [CNT_W-1:0] cnt;

    assign cfg_in = '{enable: cfg_enable, arm: cfg_arm,
                      begin_mode: cfg_begin, brk_en: cfg_brk_en};

    dbg_trig_qual #(.TRACK_LAT(TRACK_LAT)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .match (cmp_match),
        .sel   (trig_sel),
        .qual  (qual)
    );

    dbg_run_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg         (cfg_in),
        .qual        (qual),
        .cap_valid   (cap_valid),
        .rd_req      (rd_req),
        .cnt         (cnt),
        .armed       (armed),
        .brk_req     (brk_req),
        .store_wr    (store_wr),
        .store_clear (store_clear),
        .store_pop   (store_pop)
    );

    dbg_trace_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (store_clear),
        .wr_en   (store_wr),
        .wr_data (cap_data),
        .pop     (store_pop),
        .rd_data (rd_data),
        .count   (cnt)
    );

    assign entry_cnt = cnt;

    p_arm_empties_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_enable && cfg_arm) |=> (armed && entry_cnt == '0));

    p_disarm_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !(cfg_enable && cfg_arm)) |=> (!armed && !brk_req));

    p_read_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && rd_req && !cap_valid && !cfg_we) |=> entry_cnt == $past(entry_cnt));

endmodule

// File: tb/dbg_trace_trig_test.sv
module dbg_trace_trig_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  cap_data = '0;
    logic          cap_valid = 1'b0, cmp_match = 1'b0, trig_sel = 1'b0;
    logic          cfg_we = 1'b0, cfg_enable = 1'b0, cfg_arm = 1'b0;
    logic          cfg_begin = 1'b0, cfg_brk_en = 1'b0, rd_req = 1'b0;
    logic [W-1:0]  rd_data;
    logic [3:0]    entry_cnt;
    logic          armed, brk_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1 reset";

    // behavioural model
    logic [W-1:0] q[$];
    int  m_st = 0;      // 0 idle, 1 waiting, 2 filling, 3 rolling
    bit  m_brk = 0, m_brken = 0, h1 = 0, h2 = 0;
    logic [W-1:0] next_word = 16'h1000;

    dbg_trace_trig uut (
        .clk(clk), .rst(rst), .cap_data(cap_data), .cap_valid(cap_valid),
        .cmp_match(cmp_match), .trig_sel(trig_sel), .cfg_we(cfg_we),
        .cfg_enable(cfg_enable), .cfg_arm(cfg_arm), .cfg_begin(cfg_begin),
        .cfg_brk_en(cfg_brk_en), .rd_req(rd_req), .rd_data(rd_data),
        .entry_cnt(entry_cnt), .armed(armed), .brk_req(brk_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit qual, stop;
        qual = trig_sel ? h2 : cmp_match;
        stop = 0;
        if (rst) begin
            q.delete(); m_st = 0; m_brken = 0; h1 = 0; h2 = 0; m_brk = 0;
            return;
        end
        if (cfg_we) begin
            if (cfg_enable && cfg_arm) begin
                q.delete();
                m_st = cfg_begin ? 1 : 3;
            end else m_st = 0;
        end else begin
            case (m_st)
                1: if (qual) m_st = 2;
                2: if (cap_valid) begin
                       q.push_back(cap_data);
                       if (q.size() == 8) stop = 1;
                   end
                3: begin
                       if (cap_valid) begin
                           q.push_back(cap_data);
                           if (q.size() > 8) void'(q.pop_front());
                       end
                       if (qual) stop = 1;
                   end
                default: if (rd_req && q.size() > 0) void'(q.pop_front());
            endcase
        end
        m_brk = stop && m_brken;
        if (cfg_we) m_brken = cfg_brk_en;
        if (stop) m_st = 0;
        h2 = h1; h1 = cmp_match;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        check("armed", armed, (m_st != 0));
        check("entry_cnt", entry_cnt, q.size());
        check("brk_req", brk_req, m_brk);
        if (q.size() > 0) check("rd_data", rd_data, q[0]);
        cfg_we = 0; cmp_match = 0; rd_req = 0; cap_valid = 0;
    endtask

    task automatic write_cfg(input bit en, input bit arm, input bit bgn, input bit brk);
        cfg_we = 1; cfg_enable = en; cfg_arm = arm; cfg_begin = bgn; cfg_brk_en = brk;
        tick();
    endtask

    task automatic feed(input bit match, input bit rd);
        cap_valid = 1; cap_data = next_word; next_word++;
        cmp_match = match; rd_req = rd;
        tick();
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin rd_req = 1; tick(); end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        tick(); tick();
        rst = 0;
        phase = "R1 reset";
        tick();

        // begin mode, raw trigger
        phase = "R2 arm begin";
        trig_sel = 0;
        write_cfg(1, 1, 1, 1);
        phase = "R5 pre-trigger words ignored";
        feed(0, 0); feed(0, 1); feed(0, 0);
        phase = "R11 read while armed";
        rd_req = 1; tick();
        phase = "R5 trigger cycle word";
        feed(1, 0);
        phase = "R6 begin fill";
        for (int i = 0; i < 5; i++) feed(0, 0);
        tick();
        for (int i = 0; i < 3; i++) feed(0, 0);
        phase = "R9 begin break pulse";
        feed(0, 0); feed(0, 0); tick();
        phase = "R10 drain";
        drain(3);

        // end mode, tracked trigger, trigger meets full buffer
        phase = "R2 rearm clears";
        trig_sel = 1;
        write_cfg(1, 1, 0, 1);
        phase = "R7 end roll";
        for (int i = 0; i < 11; i++) feed(0, (i == 4));
        phase = "R4 tracked trigger";
        feed(1, 0);
        feed(0, 0);
        phase = "R8 end freeze";
        feed(0, 0);
        phase = "R9 end break";
        feed(0, 0); tick();
        phase = "R10 drain end";
        drain(9);

        // raw trigger in end mode, breaks disabled
        phase = "R9 no break when disabled";
        trig_sel = 0;
        write_cfg(1, 1, 0, 0);
        feed(0, 0); feed(0, 0); feed(1, 0); feed(0, 0); tick();
        drain(3);

        // software disarm
        phase = "R3 disarm by arm=0";
        write_cfg(1, 1, 0, 1);
        feed(0, 0); feed(0, 0);
        write_cfg(1, 0, 0, 1);
        feed(1, 0); tick();
        phase = "R3 disarm by enable=0";
        write_cfg(1, 1, 1, 1);
        feed(1, 0); feed(0, 0);
        write_cfg(0, 1, 1, 1);
        feed(0, 0); tick();
        drain(2);

        // tracked match issued before arming lands after arming
        phase = "R4 early tracked match";
        trig_sel = 1;
        cmp_match = 1; tick();
        write_cfg(1, 1, 1, 1);
        for (int i = 0; i < 10; i++) feed(0, 0);
        tick(); tick();
        drain(8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule